// File: doc/BRIEF.md
# Misaligned Load Split-and-Merge Buffer

This block holds one load whose bytes straddle a 16-byte line boundary. When the load pipeline finds such a load, it hands the load over through an enqueue handshake. The buffer works out two aligned sub-loads, one below the boundary and one above it. It sends them back into the load pipeline one after the other and keeps the data fragments that return. It then joins the fragments into the architectural result, with sign or zero extension.

Before the result leaves, the buffer raises a one-cycle wake-up pseudo-op. The pipeline echoes it back, tagged as a wake-up, three cycles later. Only then does the buffer present the result. It uses the scalar result port or the vector merge port, depending on the load. On either port it yields to the neighbouring pipeline whenever that pipeline is writing back on the same path.

Sub-load replays are retried without looking at their cause. A sub-load exception ends the operation early. A misaligned load to device space is never split: it finishes with an address-misaligned exception. A redirect that covers the held load empties the buffer.

Top module: `misalign_load_buffer`

## Requirements
- R1: After reset `full`, `enq_ready`, `split_req_valid`, `wake_valid`, `wb_valid` and `vwb_valid` are all low.
- R2: `enq_ready` is high only while the buffer is empty, no redirect is present, and the offered load is misaligned and crosses a 16-byte boundary. The size codes are 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. `full` is high from the cycle after an accepted enqueue until the cycle after the result leaves.
- R3: A halfword produces two byte sub-loads, at the load address and at the address plus one. A word or doubleword produces two sub-loads of its own size. The first (`split_req_hi` = 0) is at the address rounded down to the size. The second (`split_req_hi` = 1) is one size above that. The low sub-load is issued first, and a request holds its address until it is accepted.
- R4: A sub-load response with `split_resp_replay` set causes the same sub-load to be requested again, whatever the cause of the replay.
- R5: If the low sub-load returns `split_resp_exc`, the high sub-load is never requested. The result leaves with `wb_exc` = 2 (access fault) and zero data. An exception on the high sub-load also gives `wb_exc` = 2.
- R6: With no exception, the result equals the loaded bytes in little-endian order. It is zero-extended when `enq_unsigned` is set and sign-extended otherwise, and `wb_exc` = 0. Sub-load data arrives right-justified.
- R7: After both fragments arrive, `wake_valid` pulses for exactly one cycle. No result is presented until a response tagged `split_resp_wake` has been received.
- R8: A scalar load leaves only on `wb_valid`, and a vector load only on `vwb_valid`, never both. `wb_valid` is low in any cycle with `other_wb_busy`, and `vwb_valid` is low in any cycle with `other_vwb_busy`. The result carries the age given at enqueue.
- R9: A device-space load issues no sub-load and no wake-up. It leaves with `wb_exc` = 1 (address misaligned).
- R10: A redirect whose age is less than or equal to the held load's age empties the buffer on the next cycle. It drops the in-flight sub-load, so a response arriving later produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Load offered for buffering |
| enq_ready | output | 1 | Buffer takes the offered load |
| enq_addr | input | ADDR_W | Byte address of the load |
| enq_size | input | 2 | Access size code |
| enq_unsigned | input | 1 | Zero-extend instead of sign-extend |
| enq_vec | input | 1 | Result goes to the vector merge port |
| enq_device | input | 1 | Address lies in device space |
| enq_age | input | AGE_W | Program-order age of the load |
| redirect_valid | input | 1 | Flush request |
| redirect_age | input | AGE_W | Oldest age being flushed |
| split_req_valid | output | 1 | Sub-load request |
| split_req_ready | input | 1 | Pipeline accepts the sub-load |
| split_req_addr | output | ADDR_W | Aligned sub-load address |
| split_req_size | output | 2 | Sub-load size code |
| split_req_hi | output | 1 | 0 = low sub-load, 1 = high sub-load |
| split_resp_valid | input | 1 | Sub-load or wake-up response |
| split_resp_replay | input | 1 | Sub-load must be retried |
| split_resp_exc | input | 1 | Sub-load raised an exception |
| split_resp_wake | input | 1 | Response is the returning wake-up |
| split_resp_data | input | XLEN | Right-justified sub-load data |
| wake_valid | output | 1 | Wake-up pseudo-op |
| other_wb_busy | input | 1 | Neighbour pipeline uses the scalar result path |
| other_vwb_busy | input | 1 | Neighbour pipeline uses the vector merge path |
| wb_valid | output | 1 | Scalar result valid |
| wb_ready | input | 1 | Scalar result taken |
| vwb_valid | output | 1 | Vector result valid |
| vwb_ready | input | 1 | Vector result taken |
| wb_data | output | XLEN | Merged and extended result |
| wb_exc | output | 2 | 0 none, 1 address misaligned, 2 access fault |
| wb_age | output | AGE_W | Age of the completed load |
| full | output | 1 | Buffer occupied |

## Verification
The bench places loads at every line offset that makes each size straddle the boundary, with signed values whose sign bit lies in the upper fragment. A wrong shift or extension would show up as corrupted or mis-extended results. Replays are injected on both sub-loads. A buffer that advanced on a replay, or retried the wrong half, would request the wrong address or return stale bytes. The bench also injects exceptions on the low sub-load, holds the neighbour busy signals randomly, and fires a redirect with a sub-load outstanding. A faulty buffer would request the high sub-load after a low fault, collide with the neighbour's writeback, or emit a result from a flushed entry.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_SPLIT, ST_REQ, ST_RESP, ST_COMB, ST_WAKE, ST_WB
   } mlb_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_DBL  = 2'd3;

   localparam logic [1:0] EXC_NONE     = 2'd0;
   localparam logic [1:0] EXC_MISALIGN = 2'd1;
   localparam logic [1:0] EXC_FAULT    = 2'd2;
endpackage

// File: rtl/mlb_splitter.sv
module mlb_splitter #(
   parameter int ADDR_W        = 40,
   parameter int LINE_BYTES    = 16,
   parameter bit HALF_AS_BYTES = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              straddles,
   output logic [ADDR_W-1:0] lo_addr,
   output logic [ADDR_W-1:0] hi_addr,
   output logic [1:0]        sub_size,
   output logic [2:0]        shift
);
   import mlb_pkg::*;
   localparam int OFF_W = $clog2(LINE_BYTES);

   logic [ADDR_W-1:0] nbytes;
   logic [ADDR_W-1:0] low_mask;
   logic [OFF_W:0]    end_off;
   logic [ADDR_W-1:0] base;

   assign nbytes   = ADDR_W'(1) << size;
   assign low_mask = nbytes - ADDR_W'(1);
   assign end_off  = {1'b0, addr[OFF_W-1:0]} + nbytes[OFF_W:0];
   assign straddles = (|(addr & low_mask)) && (end_off > (OFF_W+1)'(LINE_BYTES));
   assign base     = addr & ~low_mask;

   generate
      if (HALF_AS_BYTES) begin : g_half_bytes
         always_comb begin
            if (size == SZ_HALF) begin
               lo_addr  = addr;
               hi_addr  = addr + ADDR_W'(1);
               sub_size = SZ_BYTE;
               shift    = 3'd0;
            end else begin
               lo_addr  = base;
               hi_addr  = base + nbytes;
               sub_size = size;
               shift    = addr[2:0] & low_mask[2:0];
            end
         end
      end else begin : g_half_aligned
         always_comb begin
            lo_addr  = base;
            hi_addr  = base + nbytes;
            sub_size = size;
            shift    = addr[2:0] & low_mask[2:0];
         end
      end
   endgenerate
endmodule

// File: rtl/mlb_merger.sv
module mlb_merger #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] lo_data,
   input  logic [XLEN-1:0] hi_data,
   input  logic [1:0]      sub_size,
   input  logic [1:0]      size,
   input  logic [2:0]      shift,
   input  logic            is_unsigned,
   output logic [XLEN-1:0] result
);
   import mlb_pkg::*;

   logic [XLEN-1:0]   frag_mask;
   logic [2*XLEN-1:0] joined;
   logic [2*XLEN-1:0] aligned;
   logic [XLEN-1:0]   raw;
   logic              sext;

   assign frag_mask = {XLEN{1'b1}} >> (XLEN - (8 << sub_size));
   assign joined    = ({{XLEN{1'b0}}, hi_data & frag_mask} << (8 << sub_size))
                    | {{XLEN{1'b0}}, lo_data & frag_mask};
   assign aligned   = joined >> {shift, 3'b000};
   assign raw       = aligned[XLEN-1:0];

   always_comb begin
      sext = 1'b0;
      unique case (size)
         SZ_BYTE: begin sext = ~is_unsigned & raw[7];  result = {{(XLEN-8){sext}},  raw[7:0]};  end
         SZ_HALF: begin sext = ~is_unsigned & raw[15]; result = {{(XLEN-16){sext}}, raw[15:0]}; end
         SZ_WORD: begin sext = ~is_unsigned & raw[31]; result = {{(XLEN-32){sext}}, raw[31:0]}; end
         default: result = raw;
      endcase
   end
endmodule

// File: rtl/misalign_load_buffer.sv
module misalign_load_buffer #(
   parameter int XLEN          = 64,
   parameter int ADDR_W        = 40,
   parameter int AGE_W         = 8,
   parameter int LINE_BYTES    = 16,
   parameter bit HALF_AS_BYTES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   output logic              enq_ready,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [1:0]        enq_size,
   input  logic              enq_unsigned,
   input  logic              enq_vec,
   input  logic              enq_device,
   input  logic [AGE_W-1:0]  enq_age,
   input  logic              redirect_valid,
   input  logic [AGE_W-1:0]  redirect_age,
   output logic              split_req_valid,
   input  logic              split_req_ready,
   output logic [ADDR_W-1:0] split_req_addr,
   output logic [1:0]        split_req_size,
   output logic              split_req_hi,
   input  logic              split_resp_valid,
   input  logic              split_resp_replay,
   input  logic              split_resp_exc,
   input  logic              split_resp_wake,
   input  logic [XLEN-1:0]   split_resp_data,
   output logic              wake_valid,
   input  logic              other_wb_busy,
   input  logic              other_vwb_busy,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic              vwb_valid,
   input  logic              vwb_ready,
   output logic [XLEN-1:0]   wb_data,
   output logic [1:0]        wb_exc,
   output logic [AGE_W-1:0]  wb_age,
   output logic              full
);
   import mlb_pkg::*;

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("misalign_load_buffer: XLEN must be 64");
      end
      if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("misalign_load_buffer: LINE_BYTES must be a power of two, at least 8");
      end
      if (AGE_W < 1 || ADDR_W <= $clog2(LINE_BYTES)) begin : g_bad_w
         $error("misalign_load_buffer: bad AGE_W or ADDR_W");
      end
   endgenerate

   mlb_state_e        state_q;
   logic [ADDR_W-1:0] lo_addr_q, hi_addr_q;
   logic [1:0]        size_q, sub_size_q, exc_q;
   logic [2:0]        shift_q;
   logic              uns_q, vec_q, dev_q, hi_sel_q;
   logic [AGE_W-1:0]  age_q;
   logic [XLEN-1:0]   lo_q, hi_q, result_q;

   logic              enq_straddles;
   logic [ADDR_W-1:0] enq_lo, enq_hi;
   logic [1:0]        enq_sub_size;
   logic [2:0]        enq_shift;
   logic [XLEN-1:0]   merged;
   logic              flush, resp_sub, wb_fire;

   mlb_splitter #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .HALF_AS_BYTES(HALF_AS_BYTES)) u_split (
      .addr(enq_addr), .size(enq_size), .straddles(enq_straddles),
      .lo_addr(enq_lo), .hi_addr(enq_hi), .sub_size(enq_sub_size), .shift(enq_shift)
   );

   mlb_merger #(.XLEN(XLEN)) u_merge (
      .lo_data(lo_q), .hi_data(hi_q), .sub_size(sub_size_q), .size(size_q),
      .shift(shift_q), .is_unsigned(uns_q), .result(merged)
   );

   assign full            = (state_q != ST_IDLE);
   assign flush           = redirect_valid && full && (age_q >= redirect_age);
   assign enq_ready       = (state_q == ST_IDLE) && !redirect_valid && enq_straddles;
   assign split_req_valid = (state_q == ST_REQ);
   assign split_req_addr  = hi_sel_q ? hi_addr_q : lo_addr_q;
   assign split_req_size  = sub_size_q;
   assign split_req_hi    = hi_sel_q;
   assign wake_valid      = (state_q == ST_COMB);
   assign resp_sub        = split_resp_valid && !split_resp_wake;
   assign wb_valid        = (state_q == ST_WB) && !vec_q && !other_wb_busy;
   assign vwb_valid       = (state_q == ST_WB) && vec_q && !other_vwb_busy;
   assign wb_fire         = (wb_valid && wb_ready) || (vwb_valid && vwb_ready);
   assign wb_data         = result_q;
   assign wb_exc          = exc_q;
   assign wb_age          = age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         lo_addr_q  <= '0;
         hi_addr_q  <= '0;
         size_q     <= SZ_BYTE;
         sub_size_q <= SZ_BYTE;
         shift_q    <= '0;
         uns_q      <= 1'b0;
         vec_q      <= 1'b0;
         dev_q      <= 1'b0;
         hi_sel_q   <= 1'b0;
         age_q      <= '0;
         exc_q      <= EXC_NONE;
         lo_q       <= '0;
         hi_q       <= '0;
         result_q   <= '0;
      end else if (flush) begin
         state_q  <= ST_IDLE;
         hi_sel_q <= 1'b0;
         exc_q    <= EXC_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (enq_valid && enq_ready) begin
               lo_addr_q  <= enq_lo;
               hi_addr_q  <= enq_hi;
               size_q     <= enq_size;
               sub_size_q <= enq_sub_size;
               shift_q    <= enq_shift;
               uns_q      <= enq_unsigned;
               vec_q      <= enq_vec;
               dev_q      <= enq_device;
               age_q      <= enq_age;
               hi_sel_q   <= 1'b0;
               exc_q      <= EXC_NONE;
               state_q    <= ST_SPLIT;
            end
            ST_SPLIT: begin
               if (dev_q) begin
                  exc_q    <= EXC_MISALIGN;
                  result_q <= '0;
                  state_q  <= ST_WB;
               end else begin
                  state_q  <= ST_REQ;
               end
            end
            ST_REQ: if (split_req_ready) state_q <= ST_RESP;
            ST_RESP: if (resp_sub) begin
               if (split_resp_replay) begin
                  state_q <= ST_REQ;
               end else if (split_resp_exc) begin
                  exc_q    <= EXC_FAULT;
                  result_q <= '0;
                  state_q  <= ST_WB;
               end else if (!hi_sel_q) begin
                  lo_q     <= split_resp_data;
                  hi_sel_q <= 1'b1;
                  state_q  <= ST_REQ;
               end else begin
                  hi_q    <= split_resp_data;
                  state_q <= ST_COMB;
               end
            end
            ST_COMB: begin
               result_q <= merged;
               state_q  <= ST_WAKE;
            end
            ST_WAKE: if (split_resp_valid && split_resp_wake) state_q <= ST_WB;
            ST_WB: if (wb_fire) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> (!split_req_valid && !wake_valid && !wb_valid && !vwb_valid));
   p_no_enq_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !enq_ready);
   p_enq_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready) |=> full);
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (split_req_valid && !split_req_ready && !flush) |=> (split_req_valid && $stable(split_req_addr)));
   p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |=> !wake_valid);
   p_wb_yield_r8: assert property (@(posedge clk) disable iff (!rst_n)
      other_wb_busy |-> !wb_valid);
   p_vwb_yield_r8: assert property (@(posedge clk) disable iff (!rst_n)
      other_vwb_busy |-> !vwb_valid);
   p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wb_valid, vwb_valid}));
   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!full && !split_req_valid));
endmodule

// File: tb/misalign_load_buffer_bench.sv
module misalign_load_buffer_bench;
   localparam int XLEN = 64;
   localparam int AW   = 40;
   localparam int AGW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enq_valid = 0, enq_unsigned = 0, enq_vec = 0, enq_device = 0;
   logic [AW-1:0] enq_addr = '0;
   logic [1:0] enq_size = '0;
   logic [AGW-1:0] enq_age = '0, redirect_age = '0;
   logic redirect_valid = 0, split_req_ready = 0;
   logic split_resp_valid = 0, split_resp_replay = 0, split_resp_exc = 0, split_resp_wake = 0;
   logic [XLEN-1:0] split_resp_data = '0;
   logic other_wb_busy = 0, other_vwb_busy = 0, wb_ready = 0, vwb_ready = 0;
   logic enq_ready, split_req_valid, split_req_hi, wake_valid, wb_valid, vwb_valid, full;
   logic [AW-1:0] split_req_addr;
   logic [1:0] split_req_size, wb_exc;
   logic [XLEN-1:0] wb_data;
   logic [AGW-1:0] wb_age;

   int n_tests = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   misalign_load_buffer u_misalign_load_buffer (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input logic [AW-1:0] a);
      return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [63:0] exp_load(input logic [AW-1:0] a, input logic [1:0] sz, input bit uns);
      logic [63:0] r = '0;
      int n = 1 << sz;
      for (int i = 0; i < n; i++) r |= 64'(mb(a + AW'(i))) << (8 * i);
      if (!uns && n < 8 && r[8*n-1]) r |= ~64'h0 << (8 * n);
      return r;
   endfunction

   function automatic logic [63:0] sub_data(input logic [AW-1:0] a, input logic [1:0] sz);
      logic [63:0] r = '0;
      for (int i = 0; i < (1 << sz); i++) r |= 64'(mb(a + AW'(i))) << (8 * i);
      return r;
   endfunction

   function automatic logic [AW-1:0] exp_sub_addr(input logic [AW-1:0] a, input logic [1:0] sz, input bit hi);
      logic [AW-1:0] n = AW'(1) << sz;
      if (sz == 2'd1) return a + AW'(hi);
      return (a & ~(n - 1)) + (hi ? n : '0);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // exc_sel: 0 none, 1 low sub-load faults, 2 high sub-load faults
   task automatic do_load(input logic [AW-1:0] a, input logic [1:0] sz, input bit uns, input bit vec,
                          input bit dev, input logic [AGW-1:0] age, input int exc_sel, input int replays);
      int resp_cnt = 0, wake_cnt = 0, nreq = 0, nwake = 0, guard = 0;
      bit resp_hi = 0, resp_wake = 0, wake_back = 0, saw_hi = 0, rep_pend = 0, rep_hi = 0, fin = 0;
      logic [AW-1:0] resp_a = '0;
      logic [1:0] resp_sz = '0;
      logic [63:0] exp_d;
      logic [1:0] exp_e;
      @(negedge clk);
      enq_addr = a; enq_size = sz; enq_unsigned = uns; enq_vec = vec; enq_device = dev; enq_age = age;
      enq_valid = 1;
      #1 chk(enq_ready, "R2", "enq_ready for straddling load", 64'(enq_ready), 64'd1);
      while (!fin && guard < 400) begin
         guard++;
         @(negedge clk);
         enq_valid = 0; split_req_ready = 0; split_resp_valid = 0; split_resp_replay = 0;
         split_resp_exc = 0; split_resp_wake = 0; wb_ready = 0; vwb_ready = 0;
         other_wb_busy = ($urandom % 4 == 0); other_vwb_busy = ($urandom % 4 == 0);
         if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
               split_resp_valid = 1;
               split_resp_data = sub_data(resp_a, resp_sz);
               if (replays > 0 && $urandom % 3 == 0) begin
                  replays--; split_resp_replay = 1; rep_pend = 1; rep_hi = resp_hi;
               end else if (exc_sel == int'(resp_hi) + 1) begin
                  split_resp_exc = 1;
               end
            end
         end
         if (wake_cnt > 0) begin
            wake_cnt--;
            if (wake_cnt == 0) begin
               split_resp_valid = 1; split_resp_wake = 1; wake_back = 1;
            end
         end
         #1;
         if (guard == 1) chk(full, "R2", "full after accept", 64'(full), 64'd1);
         if (split_req_valid && $urandom % 3 != 0) begin
            split_req_ready = 1; nreq++;
            if (split_req_hi) saw_hi = 1;
            chk(split_req_addr == exp_sub_addr(a, sz, split_req_hi), "R3", "sub-load address",
                64'(split_req_addr), 64'(exp_sub_addr(a, sz, split_req_hi)));
            chk(split_req_size == (sz == 2'd1 ? 2'd0 : sz), "R3", "sub-load size",
                64'(split_req_size), 64'(sz == 2'd1 ? 2'd0 : sz));
            if (nreq == 1) chk(!split_req_hi, "R3", "low sub-load first", 64'(split_req_hi), 64'd0);
            if (rep_pend) begin
               chk(split_req_hi == rep_hi, "R4", "replayed sub-load reissued", 64'(split_req_hi), 64'(rep_hi));
               rep_pend = 0;
            end
            resp_a = split_req_addr; resp_sz = split_req_size; resp_hi = split_req_hi;
            resp_cnt = 1 + $urandom % 3;
         end
         if (wake_valid) begin nwake++; wake_cnt = 3; end
         if ((other_wb_busy && wb_valid) || (other_vwb_busy && vwb_valid))
            chk(0, "R8", "result during neighbour writeback", 64'({wb_valid, vwb_valid}), 64'd0);
         if (wb_valid || vwb_valid) begin
            chk(vec ? (vwb_valid && !wb_valid) : (wb_valid && !vwb_valid), "R8", "result port",
                64'({vwb_valid, wb_valid}), vec ? 64'd2 : 64'd1);
            if (!dev && exc_sel == 0)
               chk(wake_back, "R7", "result before wake return", 64'(wake_back), 64'd1);
            if ($urandom % 2 == 0) begin
               wb_ready = 1; vwb_ready = 1; fin = 1;
               exp_e = dev ? 2'd1 : (exc_sel != 0 ? 2'd2 : 2'd0);
               exp_d = (exp_e != 0) ? 64'd0 : exp_load(a, sz, uns);
               chk(wb_exc == exp_e, dev ? "R9" : "R5", "exception code", 64'(wb_exc), 64'(exp_e));
               chk(wb_data == exp_d, exp_e == 0 ? "R6" : "R5", "result data", wb_data, exp_d);
               chk(wb_age == age, "R8", "result age", 64'(wb_age), 64'(age));
            end
         end
      end
      chk(fin, "R7", "load completed", 64'(fin), 64'd1);
      if (dev) chk(nreq == 0 && nwake == 0, "R9", "device load issued sub-loads", 64'(nreq), 64'd0);
      else if (exc_sel == 1) chk(!saw_hi, "R5", "high sub-load after low fault", 64'(saw_hi), 64'd0);
      else if (exc_sel == 0) chk(nwake == 1, "R7", "wake pulses", 64'(nwake), 64'd1);
      @(negedge clk);
      wb_ready = 0; vwb_ready = 0; other_wb_busy = 0; other_vwb_busy = 0; split_req_ready = 0;
      split_resp_valid = 0; split_resp_wake = 0;
      #1 chk(!full, "R2", "full released after result", 64'(full), 64'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      #23 rst_n = 1;
      @(negedge clk);
      chk(!full && !enq_ready && !split_req_valid && !wake_valid && !wb_valid && !vwb_valid, "R1",
          "outputs after reset", 64'({full, enq_ready, split_req_valid, wake_valid, wb_valid, vwb_valid}), 64'd0);

      // R2: aligned or non-straddling loads are refused
      enq_addr = 40'h1008; enq_size = 2'd3; enq_valid = 1;
      #1 chk(!enq_ready, "R2", "aligned dword refused", 64'(enq_ready), 64'd0);
      @(negedge clk);
      enq_addr = 40'h1005; enq_size = 2'd1;
      #1 chk(!enq_ready, "R2", "misaligned half within line refused", 64'(enq_ready), 64'd0);
      @(negedge clk);
      enq_addr = 40'h100F; enq_size = 2'd0;
      #1 chk(!enq_ready, "R2", "byte never taken", 64'(enq_ready), 64'd0);
      @(negedge clk);
      enq_valid = 0;
      #1 chk(!full, "R2", "refused load left buffer empty", 64'(full), 64'd0);

      // directed corners
      do_load(40'h20F, 2'd1, 0, 0, 0, 8'd3, 0, 0);    // R6 half across line
      do_load(40'h31D, 2'd2, 0, 1, 0, 8'd4, 0, 0);    // R6 word offset 13, vector
      do_load(40'h409, 2'd3, 1, 0, 0, 8'd5, 0, 1);    // R4 dword offset 9
      do_load(40'h50F, 2'd3, 0, 0, 0, 8'd6, 0, 2);    // R4 dword offset 15
      do_load(40'h60E, 2'd2, 0, 0, 0, 8'd7, 1, 0);    // R5 low fault
      do_load(40'h70F, 2'd2, 0, 1, 0, 8'd8, 2, 0);    // R5 high fault
      do_load(40'h80B, 2'd3, 0, 0, 1, 8'd9, 0, 0);    // R9 device

      // R10: redirect with a sub-load in flight
      @(negedge clk);
      enq_addr = 40'h90D; enq_size = 2'd2; enq_unsigned = 0; enq_vec = 0; enq_device = 0;
      enq_age = 8'd20; enq_valid = 1;
      @(negedge clk);
      enq_valid = 0;
      for (int i = 0; i < 10 && !split_req_valid; i++) @(negedge clk);
      split_req_ready = 1;
      @(negedge clk);
      split_req_ready = 0; redirect_valid = 1; redirect_age = 8'd15;
      @(negedge clk);
      redirect_valid = 0;
      #1 chk(!full, "R10", "full after redirect", 64'(full), 64'd0);
      @(negedge clk);
      split_resp_valid = 1; split_resp_data = 64'hDEAD;
      @(negedge clk);
      split_resp_valid = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         #1 chk(!wb_valid && !vwb_valid && !split_req_valid && !full, "R10", "output after flush",
                64'({wb_valid, vwb_valid, split_req_valid, full}), 64'd0);
      end

      // random straddling loads
      for (int k = 0; k < 60; k++) begin
         logic [1:0] sz = 2'(1 + $urandom % 3);
         int n = 1 << sz;
         int off = 16 - 1 - int'($urandom % (n - 1));
         logic [AW-1:0] a = {AW'($urandom) << 4} | AW'(off);
         int es = ($urandom % 8 == 0) ? int'(1 + $urandom % 2) : 0;
         do_load(a, sz, $urandom % 2, $urandom % 2, ($urandom % 10 == 0), AGW'($urandom), es, $urandom % 3);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule